// File: doc/BRIEF.md
# Multiprocessor Mailbox Barrier Hub

This block is a shared message hub for a small cluster of processors. Every processor owns one mailbox, and each mailbox is a first-in-first-out queue of 32-bit words. Any processor may post a word into any mailbox. Only the owner, identified by a constant ID input wired per processor, takes words out of its own mailbox or asks how many are waiting. All mailboxes share one 512-word on-chip array, split into equal fixed slices.

Each processor has a small request port. A two-bit opcode selects idle, post, pend or status, and a wait output stalls the processor until the request can complete. When several processors post to one mailbox in the same cycle, a fixed-priority arbiter admits one of them and makes the rest wait, so every post lands whole and in a defined order. A pend on an empty mailbox waits until a word arrives. A post to a full mailbox waits until there is room.

Software builds a barrier from these primitives. On arrival, each processor posts one token into every mailbox except its own. It then pends until it has drained N-1 tokens. No processor can pass until the last one has arrived.

Top module: `mbox_barrier_hub`

## Requirements
- R1: While rst_n is low, and after it is released, every mailbox is empty: a status request returns 0 and a pend request waits.
- R2: A pend (opcode 2'b10) on a non-empty mailbox completes in the cycle it is presented (wait low) and returns on cpu_rdata the oldest word in that mailbox. Words leave in the order they were accepted.
- R3: A post (opcode 2'b01) writes the CPU's cpu_wdata into the mailbox numbered by its cpu_tgt. Pend and status act on the mailbox numbered by the CPU's own cpu_id. CPU c uses bit slice [c*W +: W] of every per-CPU bus of width W.
- R4: When several CPUs post to one mailbox in the same cycle, the lowest-indexed CPU is accepted and every other one sees wait high. The losers are accepted in later cycles, one per cycle, in index order.
- R5: Posts from different CPUs to different non-full mailboxes in the same cycle are all accepted in that cycle.
- R6: A pend on an empty mailbox holds wait high and removes nothing. It completes in the cycle after another CPU's post to that mailbox is accepted.
- R7: Each mailbox holds TOTAL_DEPTH/NCPU words (128 by default). A post to a full mailbox waits, and no word is dropped or overwritten.
- R8: A status request (opcode 2'b11) completes at once with wait low. It returns the mailbox's word count, zero-extended, and leaves the mailbox unchanged. Opcode 2'b00 is idle.
- R9: A pend and a post that hit the same non-empty mailbox in one cycle both complete, and the word count stays the same.
- R10: When each CPU posts one token to every other mailbox and then pends N-1 times, no CPU finishes its pends before the last CPU has started posting. All CPUs then pass, and every mailbox is left empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_id | input | NCPU*IDW | Constant ID of each CPU; selects its own mailbox |
| cpu_op | input | NCPU*2 | Per-CPU opcode: 00 idle, 01 post, 10 pend, 11 status |
| cpu_tgt | input | NCPU*IDW | Per-CPU target mailbox of a post |
| cpu_wdata | input | NCPU*DW | Per-CPU word to post |
| cpu_rdata | output | NCPU*DW | Per-CPU pend data or status count |
| cpu_wait | output | NCPU | Per-CPU stall: the request did not complete this cycle |

## Verification
Two results are due in the same cycle as the request: cpu_wait, and the pend data or status count. They settle from the state registered at the previous edge plus the current inputs. The bench drives inputs at the falling edge and samples 1 ns later, before the rising edge that commits the request. The effects of an accepted request (new counts, arriving words, a freed slot) can only show up from the following cycle. For that reason the bench updates its reference queues only after each sampled cycle, and it predicts the next cycle's wait and data from the updated queues.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POST = 2'b01,
    OP_PEND = 2'b10,
    OP_STAT = 2'b11
  } mbx_op_e;
endpackage

// File: rtl/mbx_prio_arb.sv
`timescale 1ns/1ps
module mbx_prio_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic taken;

  always_comb begin
    gnt   = '0;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbx_queue.sv
`timescale 1ns/1ps
module mbx_queue #(
  parameter int SLOT = 128,
  parameter int PW   = 7,
  parameter int CW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [PW-1:0] wr_nxt, rd_nxt;
  logic [CW-1:0] cnt_nxt;
  logic          upd_en;

  assign full   = (count == CW'(SLOT));
  assign empty  = (count == '0);
  assign upd_en = push | pop;

  always_comb begin
    wr_nxt  = wr_ptr;
    rd_nxt  = rd_ptr;
    cnt_nxt = count;
    if (push) wr_nxt = (wr_ptr == PW'(SLOT - 1)) ? '0 : wr_ptr + 1'b1;
    if (pop)  rd_nxt = (rd_ptr == PW'(SLOT - 1)) ? '0 : rd_ptr + 1'b1;
    if (push && !pop)      cnt_nxt = count + 1'b1;
    else if (pop && !push) cnt_nxt = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (upd_en) begin
      wr_ptr <= wr_nxt;
      rd_ptr <= rd_nxt;
      count  <= cnt_nxt;
    end
  end
endmodule

// File: rtl/mbox_barrier_hub.sv
`timescale 1ns/1ps
module mbox_barrier_hub
  import mbx_pkg::*;
#(
  parameter int NCPU        = 4,
  parameter int DW          = 32,
  parameter int TOTAL_DEPTH = 512,
  localparam int IDW        = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCPU*IDW-1:0] cpu_id,
  input  logic [NCPU*2-1:0]   cpu_op,
  input  logic [NCPU*IDW-1:0] cpu_tgt,
  input  logic [NCPU*DW-1:0]  cpu_wdata,
  output logic [NCPU*DW-1:0]  cpu_rdata,
  output logic [NCPU-1:0]     cpu_wait
);
  localparam int SLOT = TOTAL_DEPTH / NCPU;
  localparam int PW   = $clog2(SLOT);
  localparam int CW   = $clog2(SLOT + 1);
  localparam int AW   = $clog2(TOTAL_DEPTH);

  logic [1:0]      op_a  [NCPU];
  logic [IDW-1:0]  id_a  [NCPU];
  logic [IDW-1:0]  tgt_a [NCPU];
  logic [DW-1:0]   wd_a  [NCPU];

  logic [NCPU-1:0] post_req [NCPU];
  logic [NCPU-1:0] gnt      [NCPU];
  logic [NCPU-1:0] pend_own;
  logic [NCPU-1:0] push, pop, full, empty;
  logic [PW-1:0]   wr_ptr [NCPU];
  logic [PW-1:0]   rd_ptr [NCPU];
  logic [CW-1:0]   cnt    [NCPU];
  logic [DW-1:0]   push_data [NCPU];
  logic [NCPU*CW-1:0] cnt_flat;

  logic [DW-1:0]   mem [TOTAL_DEPTH];

  function automatic logic [AW-1:0] slot_addr(input int m, input logic [PW-1:0] p);
    return AW'(m * SLOT) + AW'(p);
  endfunction

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      op_a[c]  = cpu_op[c*2 +: 2];
      id_a[c]  = cpu_id[c*IDW +: IDW];
      tgt_a[c] = cpu_tgt[c*IDW +: IDW];
      wd_a[c]  = cpu_wdata[c*DW +: DW];
    end
  end

  // request routing: posts by target, pends by owner ID
  always_comb begin
    for (int m = 0; m < NCPU; m++) begin
      pend_own[m] = 1'b0;
      for (int c = 0; c < NCPU; c++) begin
        post_req[m][c] = (op_a[c] == OP_POST) && (tgt_a[c] == IDW'(m));
        if ((op_a[c] == OP_PEND) && (id_a[c] == IDW'(m))) pend_own[m] = 1'b1;
      end
    end
  end

  for (genvar m = 0; m < NCPU; m++) begin : g_box
    mbx_prio_arb #(.N(NCPU)) u_arb (
      .req (post_req[m]),
      .gnt (gnt[m])
    );

    mbx_queue #(.SLOT(SLOT), .PW(PW), .CW(CW)) u_q (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (push[m]),
      .pop    (pop[m]),
      .wr_ptr (wr_ptr[m]),
      .rd_ptr (rd_ptr[m]),
      .count  (cnt[m]),
      .full   (full[m]),
      .empty  (empty[m])
    );
  end

  always_comb begin
    for (int m = 0; m < NCPU; m++) begin
      push[m]      = (|gnt[m]) && !full[m];
      pop[m]       = pend_own[m] && !empty[m];
      push_data[m] = '0;
      for (int c = 0; c < NCPU; c++) begin
        if (gnt[m][c]) push_data[m] = wd_a[c];
      end
      cnt_flat[m*CW +: CW] = cnt[m];
    end
  end

  // shared storage, one write port per mailbox slice
  always_ff @(posedge clk) begin
    for (int m = 0; m < NCPU; m++) begin
      if (push[m]) mem[slot_addr(m, wr_ptr[m])] <= push_data[m];
    end
  end

  // per-CPU response: stall and read data
  always_comb begin
    cpu_wait  = '0;
    cpu_rdata = '0;
    for (int c = 0; c < NCPU; c++) begin
      case (mbx_op_e'(op_a[c]))
        OP_POST: cpu_wait[c] = !(gnt[tgt_a[c]][c] && !full[tgt_a[c]]);
        OP_PEND: begin
          cpu_wait[c] = empty[id_a[c]];
          cpu_rdata[c*DW +: DW] = mem[slot_addr(int'(id_a[c]), rd_ptr[id_a[c]])];
        end
        OP_STAT: cpu_rdata[c*DW +: DW] = DW'(cnt[id_a[c]]);
        default: cpu_wait[c] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mbx_hub_chk.sv
`timescale 1ns/1ps
module mbx_hub_chk
  import mbx_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int IDW  = 2,
  parameter int SLOT = 128,
  parameter int CW   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCPU*IDW-1:0] cpu_id,
  input logic [NCPU*2-1:0]   cpu_op,
  input logic [NCPU*IDW-1:0] cpu_tgt,
  input logic [NCPU-1:0]     cpu_wait,
  input logic [NCPU*CW-1:0]  cnt_flat
);
  logic [1:0]      op_c  [NCPU];
  logic [IDW-1:0]  id_c  [NCPU];
  logic [IDW-1:0]  tgt_c [NCPU];
  logic [CW-1:0]   cnt_m [NCPU];
  logic [NCPU-1:0] acc_post [NCPU];
  logic [NCPU-1:0] lower_post;

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      op_c[c]  = cpu_op[c*2 +: 2];
      id_c[c]  = cpu_id[c*IDW +: IDW];
      tgt_c[c] = cpu_tgt[c*IDW +: IDW];
      cnt_m[c] = cnt_flat[c*CW +: CW];
    end
  end

  always_comb begin
    for (int m = 0; m < NCPU; m++) begin
      for (int c = 0; c < NCPU; c++) begin
        acc_post[m][c] = (op_c[c] == OP_POST) && (tgt_c[c] == IDW'(m)) && !cpu_wait[c];
      end
    end
    for (int c = 0; c < NCPU; c++) begin
      lower_post[c] = 1'b0;
      for (int d = 0; d < c; d++) begin
        if ((op_c[c] == OP_POST) && (op_c[d] == OP_POST) && (tgt_c[d] == tgt_c[c]))
          lower_post[c] = 1'b1;
      end
    end
  end

  for (genvar m = 0; m < NCPU; m++) begin : g_box_chk
    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_m[m] <= CW'(SLOT));

    // R4
    one_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(acc_post[m]) <= 1);

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt_m[m] == $past(cnt_m[m])) || (cnt_m[m] == $past(cnt_m[m]) + 1'b1)
               || (cnt_m[m] + 1'b1 == $past(cnt_m[m])));

    // R1
    always @(posedge clk) begin
      if (!rst_n) begin
        reset_clear_chk: assert (cnt_m[m] == '0);
      end
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu_chk
    // R6
    pend_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_c[c] == OP_PEND) && (cnt_m[id_c[c]] == '0)) |-> cpu_wait[c]);

    // R4
    prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lower_post[c] |-> cpu_wait[c]);

    // R8
    stat_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_c[c] == OP_STAT) |-> !cpu_wait[c]);
  end
endmodule

bind mbox_barrier_hub mbx_hub_chk #(
  .NCPU (NCPU),
  .IDW  (IDW),
  .SLOT (SLOT),
  .CW   (CW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_id   (cpu_id),
  .cpu_op   (cpu_op),
  .cpu_tgt  (cpu_tgt),
  .cpu_wait (cpu_wait),
  .cnt_flat (cnt_flat)
);

// File: tb/mbox_barrier_hub_bench.sv
`timescale 1ns/1ps
module mbox_barrier_hub_bench;
  localparam int NCPU  = 4;
  localparam int DW    = 32;
  localparam int TOTAL = 512;
  localparam int SLOT  = TOTAL / NCPU;
  localparam int IDW   = 2;

  localparam logic [1:0] IDLE = 2'b00, POST = 2'b01, PEND = 2'b10, STAT = 2'b11;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic [1:0]     op_v  [NCPU];
  logic [IDW-1:0] tgt_v [NCPU];
  logic [DW-1:0]  wd_v  [NCPU];

  logic [NCPU*IDW-1:0] id_f, tgt_f;
  logic [NCPU*2-1:0]   op_f;
  logic [NCPU*DW-1:0]  wd_f, rd_f;
  logic [NCPU-1:0]     wait_f;

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      id_f[c*IDW +: IDW]  = IDW'(c);
      tgt_f[c*IDW +: IDW] = tgt_v[c];
      op_f[c*2 +: 2]      = op_v[c];
      wd_f[c*DW +: DW]    = wd_v[c];
    end
  end

  mbox_barrier_hub #(.NCPU(NCPU), .DW(DW), .TOTAL_DEPTH(TOTAL)) u_mbox_barrier_hub (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_id    (id_f),
    .cpu_op    (op_f),
    .cpu_tgt   (tgt_f),
    .cpu_wdata (wd_f),
    .cpu_rdata (rd_f),
    .cpu_wait  (wait_f)
  );

  // reference queues
  logic [DW-1:0] mbuf [NCPU][SLOT];
  int mhead [NCPU];
  int mcnt  [NCPU];

  int checks = 0;
  int errors = 0;
  bit last_wait [NCPU];
  logic [DW-1:0] last_rd [NCPU];
  int cyc = 0;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cpu-cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic idle_all();
    for (int c = 0; c < NCPU; c++) begin
      op_v[c] = IDLE; tgt_v[c] = '0; wd_v[c] = '0;
    end
  endtask

  function automatic void model_clear();
    for (int m = 0; m < NCPU; m++) begin
      mhead[m] = 0; mcnt[m] = 0;
    end
  endfunction

  // one cycle: inputs already set at the falling edge
  task automatic step();
    int  winner [NCPU];
    bit  acc    [NCPU];
    bit  expw;
    #1;
    for (int m = 0; m < NCPU; m++) begin
      winner[m] = -1;
      for (int c = NCPU - 1; c >= 0; c--)
        if (op_v[c] == POST && int'(tgt_v[c]) == m) winner[m] = c;
    end
    for (int c = 0; c < NCPU; c++) begin
      acc[c] = 1'b0;
      last_wait[c] = wait_f[c];
      last_rd[c]   = rd_f[c*DW +: DW];
      case (op_v[c])
        POST: begin
          expw = !(winner[tgt_v[c]] == c && mcnt[tgt_v[c]] < SLOT);
          if (winner[tgt_v[c]] != c)       chk("R4 lost arbitration wait", DW'(wait_f[c]), DW'(expw));
          else if (mcnt[tgt_v[c]] >= SLOT) chk("R7 full post wait", DW'(wait_f[c]), DW'(expw));
          else                             chk("R3 R5 post wait", DW'(wait_f[c]), DW'(expw));
          acc[c] = !expw;
        end
        PEND: begin
          expw = (mcnt[c] == 0);
          chk("R6 pend wait", DW'(wait_f[c]), DW'(expw));
          if (!expw) chk("R2 R3 pend data", rd_f[c*DW +: DW], mbuf[c][mhead[c]]);
          acc[c] = !expw;
        end
        STAT: begin
          chk("R8 status wait", DW'(wait_f[c]), '0);
          chk("R8 status count", rd_f[c*DW +: DW], DW'(mcnt[c]));
        end
        default: ;
      endcase
    end
    for (int c = 0; c < NCPU; c++) begin
      if (op_v[c] == PEND && acc[c]) begin
        mhead[c] = (mhead[c] + 1) % SLOT;
        mcnt[c]--;
      end
    end
    for (int c = 0; c < NCPU; c++) begin
      if (op_v[c] == POST && acc[c]) begin
        mbuf[tgt_v[c]][(mhead[tgt_v[c]] + mcnt[tgt_v[c]]) % SLOT] = wd_v[c];
        mcnt[tgt_v[c]]++;
      end
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic do_reset();
    idle_all();
    rst_n = 1'b0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int start_c [NCPU];
    int next_t  [NCPU];
    int need    [NCPU];
    int done_c  [NCPU];
    int r;
    int acc_n;
    void'($urandom(32'd9127));
    idle_all();
    model_clear();
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    for (int c = 0; c < NCPU; c++) op_v[c] = STAT;
    #1;
    for (int c = 0; c < NCPU; c++) chk("R1 status after reset", rd_f[c*DW +: DW], '0);
    #0 step();
    for (int c = 0; c < NCPU; c++) op_v[c] = PEND;
    #1;
    for (int c = 0; c < NCPU; c++) chk("R1 pend waits after reset", DW'(wait_f[c]), 32'd1);
    #0 step();

    // R5: four posts to four distinct mailboxes
    for (int c = 0; c < NCPU; c++) begin
      op_v[c] = POST; tgt_v[c] = IDW'((c + 1) % NCPU); wd_v[c] = 32'hA000 + c;
    end
    step();
    for (int c = 0; c < NCPU; c++) chk("R5 distinct targets accepted", DW'(last_wait[c]), '0);
    // drain each one
    for (int c = 0; c < NCPU; c++) op_v[c] = PEND;
    step();
    for (int c = 0; c < NCPU; c++)
      chk("R3 word routed by target", last_rd[c], 32'hA000 + DW'((c + NCPU - 1) % NCPU));

    // R4: all CPUs post to mailbox 0 together
    for (int c = 0; c < NCPU; c++) begin
      op_v[c] = POST; tgt_v[c] = '0; wd_v[c] = 32'h100 + c;
    end
    for (int k = 0; k < NCPU; k++) begin
      step();
      acc_n = 0;
      for (int c = 0; c < NCPU; c++) if (op_v[c] == POST && !last_wait[c]) acc_n++;
      chk("R4 one post accepted per cycle", DW'(acc_n), 32'd1);
      for (int c = 0; c < NCPU; c++) if (op_v[c] == POST && !last_wait[c]) op_v[c] = IDLE;
    end
    idle_all();
    op_v[0] = PEND;
    for (int k = 0; k < NCPU; k++) begin
      step();
      chk("R4 arbitration order", last_rd[0], 32'h100 + k);
    end

    // R6: pend on empty, then a post arrives
    idle_all();
    op_v[1] = PEND;
    step();
    chk("R6 empty pend stalls", DW'(last_wait[1]), 32'd1);
    op_v[2] = POST; tgt_v[2] = 2'd1; wd_v[2] = 32'hBEEF;
    step();
    chk("R6 still waiting in post cycle", DW'(last_wait[1]), 32'd1);
    op_v[2] = IDLE;
    step();
    chk("R6 completes next cycle", DW'(last_wait[1]), '0);
    chk("R6 delivered word", last_rd[1], 32'hBEEF);

    // R7: fill mailbox 2 from CPU0
    idle_all();
    acc_n = 0;
    op_v[0] = POST; tgt_v[0] = 2'd2;
    for (int k = 0; k < SLOT + 3; k++) begin
      wd_v[0] = 32'h7000 + acc_n;
      step();
      if (!last_wait[0]) acc_n++;
    end
    chk("R7 accepted up to capacity", DW'(acc_n), DW'(SLOT));
    chk("R7 post to full waits", DW'(last_wait[0]), 32'd1);
    idle_all();
    op_v[2] = STAT;
    step();
    chk("R7 count at capacity", last_rd[2], DW'(SLOT));
    op_v[2] = PEND;
    for (int k = 0; k < SLOT; k++) begin
      step();
      if (k == 0 || k == SLOT - 1) chk("R7 no word lost or overwritten", last_rd[2], 32'h7000 + k);
    end

    // R9: pend and post together on a non-empty mailbox
    idle_all();
    op_v[0] = POST; tgt_v[0] = 2'd3; wd_v[0] = 32'h33;
    step();
    op_v[0] = IDLE;
    op_v[3] = PEND;
    op_v[1] = POST; tgt_v[1] = 2'd3; wd_v[1] = 32'h44;
    step();
    chk("R9 pend completes", DW'(last_wait[3]), '0);
    chk("R9 post completes", DW'(last_wait[1]), '0);
    idle_all();
    op_v[3] = STAT;
    step();
    chk("R9 count unchanged", last_rd[3], 32'd1);

    // random traffic: filling phase then draining phase
    for (int k = 0; k < 4000; k++) begin
      for (int c = 0; c < NCPU; c++) begin
        r = $urandom % 100;
        if (k < 2000) op_v[c] = (r < 55) ? POST : (r < 70) ? PEND : (r < 85) ? STAT : IDLE;
        else          op_v[c] = (r < 15) ? POST : (r < 70) ? PEND : (r < 85) ? STAT : IDLE;
        tgt_v[c] = IDW'($urandom % NCPU);
        wd_v[c]  = $urandom;
      end
      step();
    end

    // R10: barrier with a late CPU
    do_reset();
    for (int c = 0; c < NCPU; c++) begin
      start_c[c] = (c == NCPU - 1) ? 30 : c;
      next_t[c]  = (c == 0) ? 1 : 0;
      need[c]    = NCPU - 1;
      done_c[c]  = -1;
    end
    for (int t = 0; t < 200; t++) begin
      for (int c = 0; c < NCPU; c++) begin
        wd_v[c] = 32'hC0 + c;
        if (t < start_c[c])          op_v[c] = IDLE;
        else if (next_t[c] < NCPU) begin op_v[c] = POST; tgt_v[c] = IDW'(next_t[c]); end
        else if (need[c] > 0)        op_v[c] = PEND;
        else                         op_v[c] = IDLE;
      end
      step();
      for (int c = 0; c < NCPU; c++) begin
        if (op_v[c] == POST && !last_wait[c]) begin
          next_t[c]++;
          if (next_t[c] == c) next_t[c]++;
        end else if (op_v[c] == PEND && !last_wait[c]) begin
          need[c]--;
          if (need[c] == 0) done_c[c] = t;
        end
      end
    end
    for (int c = 0; c < NCPU; c++) begin
      chk("R10 barrier passed", DW'(done_c[c] >= 0), 32'd1);
      chk("R10 not released before last arrival", DW'(done_c[c] > start_c[NCPU-1]), 32'd1);
    end
    idle_all();
    for (int c = 0; c < NCPU; c++) op_v[c] = STAT;
    step();
    for (int c = 0; c < NCPU; c++) chk("R10 mailboxes empty after barrier", last_rd[c], '0);

    summary();
    $finish;
  end
endmodule